// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a single word-wide host port and an asynchronous DRAM whose row and column addresses share one set of address pins. Each host request carries a row-and-column word address, a direction flag and, for stores, a data word. The controller opens the addressed row with a row strobe. It presents the column and fires a column strobe. It returns read data on a one-cycle response pulse.

The row stays open after each access. A later request to the same row becomes a column-only access with a short latency. A request to another row first closes the open row, waits out the row-cycle minimum and then opens the new row. Every analog minimum is given in nanoseconds and is turned into a whole number of cycles from a clock-period parameter. A refresh timer runs row-only refresh cycles that walk every row once per refresh period. A due refresh takes precedence over waiting host traffic.

Top module: `dram_pm_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: The row is `req_addr[21:11]` and the column is `req_addr[10:0]`. The row is on `dram_addr` when `dram_ras_n` falls and the column is on it when `dram_cas_n` falls. `dram_cas_n` is low only while `dram_ras_n` is low.
- R3: For a write (`req_write`=1), `dram_we_n` is low and `dram_dq_oe` is high with the write data on `dram_dq_out` when `dram_cas_n` falls. A later read of the same address returns that data.
- R4: A read response (`rsp_valid` high, data on `rsp_rdata`) comes at least the RAS-to-data cycle count after the last `dram_ras_n` fall, and at least the CAS-to-data cycle count after the last `dram_cas_n` fall.
- R5: Two falls of `dram_ras_n` are at least the row-cycle count of clock edges apart.
- R6: Two falls of `dram_cas_n` are at least the column-cycle count of clock edges apart.
- R7: A request that hits the open row causes no `dram_ras_n` transition. A read hit responds 1 + CAS-to-data cycles after the accepting edge, which is 3 cycles at the default values.
- R8: A request to a different row closes the open row. `dram_ras_n` falls on the edge that accepts the request. A read that opens a row responds max(RAS-to-data, 2 + CAS-to-data) cycles after acceptance, which is 6 cycles at the default values.
- R9: Refresh cycles drop `dram_ras_n` with `dram_cas_n` held high. The refreshed row starts at 0 and increases by one each time, wrapping at the row count. Refresh cycles start every floor(refresh period / (rows x clock period)) cycles, which is 390 at the default values, with a bounded delay.
- R10: While a refresh is pending, `req_ready` is low, so continuous host traffic cannot delay a refresh beyond that bound.
- R11: Each nanosecond minimum becomes ceil(ns / clock period) cycles. For example, 15 ns at a 10 ns period gives 2 cycles, not 1.
- R12: Each accepted read produces exactly one single-cycle `rsp_valid` pulse. Writes produce none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 22 | Row (upper 11) and column (lower 11) |
| req_wdata | input | 16 | Store data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The assertions assume the DRAM presents valid read data once the CAS-to-data time has passed after the column strobe, and the host holds a request steady until it sees ready. The bench's memory model loads read data on the falling clock after the column strobe drops, which keeps it within that assumption. The driver changes requests only on falling clock edges and holds them until acceptance. Each address must fit the 11-bit row and column fields, and all stimulus stays within them.

// File: rtl/dram_pm_pkg.sv
package dram_pm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_CAS,
      ST_OPEN,
      ST_PRE,
      ST_REF
   } dram_state_t;

   // Minimum time in ns converted to whole clock cycles, rounded up.
   function automatic int ns_to_cyc(input int ns, input int period);
      return (ns + period - 1) / period;
   endfunction

endpackage

// File: rtl/dram_pm_gap_timer.sv
// Minimum-gap timer: done is high from N edges after a start onward.
module dram_pm_gap_timer #(
   parameter int N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N <= 1) begin : g_none
         assign done = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (start)
               cnt <= CW'(N - 1);
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign done = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/dram_pm_refresh.sv
// Refresh interval ticker with a walking row counter.
module dram_pm_refresh #(
   parameter int INTERVAL = 390,
   parameter int ROW_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   output logic             due,
   output logic [ROW_W-1:0] row
);
   localparam int CW = $clog2(INTERVAL + 1);

   logic [CW-1:0] cnt;
   logic          tick;

   generate
      if (INTERVAL < 2) begin : g_bad
         $error("refresh interval too short");
      end
   endgenerate

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(INTERVAL - 1);
         due <= 1'b0;
         row <= '0;
      end else begin
         cnt <= tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
         if (tick)
            due <= 1'b1;
         else if (ack)
            due <= 1'b0;
         if (ack)
            row <= row + 1'b1;
      end
   end

endmodule

// File: rtl/dram_pm_ctrl.sv
module dram_pm_ctrl
   import dram_pm_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ROW_W     = 11,
   parameter int COL_W     = 11,
   parameter int CLK_NS    = 10,
   parameter int T_RAC_NS  = 60,
   parameter int T_CAC_NS  = 15,
   parameter int T_RC_NS   = 110,
   parameter int T_PC_NS   = 35,
   parameter int T_REF_NS  = 8000000
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   output logic                             req_ready,
   input  logic                             req_write,
   input  logic [ROW_W+COL_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]                req_wdata,
   output logic                             rsp_valid,
   output logic [DATA_W-1:0]                rsp_rdata,
   output logic                             dram_ras_n,
   output logic                             dram_cas_n,
   output logic                             dram_we_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]                dram_dq_out,
   output logic                             dram_dq_oe,
   input  logic [DATA_W-1:0]                dram_dq_in
);
   localparam int ADDR_W      = ROW_W + COL_W;
   localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int RAC_CYC     = ns_to_cyc(T_RAC_NS, CLK_NS);
   localparam int CAC_CYC     = ns_to_cyc(T_CAC_NS, CLK_NS);
   localparam int RC_CYC      = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int PC_CYC      = ns_to_cyc(T_PC_NS, CLK_NS);
   localparam int REF_INT_CYC = T_REF_NS / ((2 ** ROW_W) * CLK_NS);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("clock period must be positive");
      end
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("widths must be positive");
      end
      if (REF_INT_CYC < 4 * RC_CYC) begin : g_bad_ref
         $error("refresh interval too short for row cycle");
      end
   endgenerate

   dram_state_t      state;
   logic [ROW_W-1:0] open_row;
   logic [COL_W-1:0] col_q;
   logic             wr_q;

   logic [ROW_W-1:0] row_in;
   logic [COL_W-1:0] col_in;
   logic             row_hit;
   logic             acc, ras_go, cas_go, ref_go;
   logic             rc_done, rac_done, pc_done, cac_done;
   logic             ref_due;
   logic [ROW_W-1:0] ref_row;

   assign row_in  = req_addr[ADDR_W-1:COL_W];
   assign col_in  = req_addr[COL_W-1:0];
   assign row_hit = (row_in == open_row);

   dram_pm_gap_timer #(.N(RC_CYC)) u_rc (
      .clk(clk), .rst_n(rst_n), .start(ras_go), .done(rc_done));
   dram_pm_gap_timer #(.N(RAC_CYC)) u_rac (
      .clk(clk), .rst_n(rst_n), .start(ras_go), .done(rac_done));
   dram_pm_gap_timer #(.N(PC_CYC)) u_pc (
      .clk(clk), .rst_n(rst_n), .start(cas_go), .done(pc_done));
   dram_pm_gap_timer #(.N(CAC_CYC)) u_cac (
      .clk(clk), .rst_n(rst_n), .start(cas_go), .done(cac_done));

   dram_pm_refresh #(.INTERVAL(REF_INT_CYC), .ROW_W(ROW_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_go), .due(ref_due), .row(ref_row));

   always_comb begin
      acc    = 1'b0;
      ref_go = 1'b0;
      cas_go = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (rc_done) begin
               if (ref_due)
                  ref_go = 1'b1;
               else
                  acc = req_valid;
            end
         end
         ST_OPEN: acc = req_valid && !ref_due && row_hit;
         ST_COL:  cas_go = pc_done;
         default: ;
      endcase
      ras_go = ref_go || (acc && (state == ST_IDLE));
   end

   assign req_ready = ((state == ST_IDLE) && rc_done && !ref_due) ||
                      ((state == ST_OPEN) && !ref_due && row_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_addr   <= '0;
         dram_dq_out <= '0;
         dram_dq_oe  <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         open_row    <= '0;
         col_q       <= '0;
         wr_q        <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (ref_go) begin
                  dram_ras_n <= 1'b0;
                  dram_addr  <= MUX_W'(ref_row);
                  state      <= ST_REF;
               end else if (acc) begin
                  dram_ras_n  <= 1'b0;
                  dram_addr   <= MUX_W'(row_in);
                  open_row    <= row_in;
                  col_q       <= col_in;
                  wr_q        <= req_write;
                  dram_dq_out <= req_wdata;
                  state       <= ST_ROW;
               end
            end
            ST_ROW: begin
               dram_addr  <= MUX_W'(col_q);
               dram_we_n  <= ~wr_q;
               dram_dq_oe <= wr_q;
               state      <= ST_COL;
            end
            ST_COL: begin
               if (cas_go) begin
                  dram_cas_n <= 1'b0;
                  state      <= ST_CAS;
               end
            end
            ST_CAS: begin
               if (rac_done && cac_done) begin
                  dram_cas_n <= 1'b1;
                  dram_we_n  <= 1'b1;
                  dram_dq_oe <= 1'b0;
                  rsp_valid  <= ~wr_q;
                  if (!wr_q)
                     rsp_rdata <= dram_dq_in;
                  state <= ST_OPEN;
               end
            end
            ST_OPEN: begin
               if (ref_due || (req_valid && !row_hit)) begin
                  dram_ras_n <= 1'b1;
                  state      <= ST_PRE;
               end else if (acc) begin
                  dram_addr   <= MUX_W'(col_in);
                  col_q       <= col_in;
                  wr_q        <= req_write;
                  dram_we_n   <= ~req_write;
                  dram_dq_oe  <= req_write;
                  dram_dq_out <= req_wdata;
                  state       <= ST_COL;
               end
            end
            ST_PRE: begin
               if (rc_done)
                  state <= ST_IDLE;
            end
            ST_REF: begin
               if (rac_done) begin
                  dram_ras_n <= 1'b1;
                  state      <= ST_PRE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dram_pm_ctrl_chk.sv
module dram_pm_ctrl_chk #(
   parameter int RAC_CYC = 6,
   parameter int CAC_CYC = 2,
   parameter int RC_CYC  = 11,
   parameter int PC_CYC  = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic dq_oe,
   input logic rsp_valid,
   input logic req_ready,
   input logic ref_due
);
   generate
      if (RC_CYC > 250 || RAC_CYC > 250 || PC_CYC > 250 || CAC_CYC > 250) begin : g_bad
         $error("timing counts exceed checker age range");
      end
   endgenerate

   logic [7:0] ras_age, cas_age;
   logic       ras_prev, cas_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_age  <= 8'hFF;
         cas_age  <= 8'hFF;
         ras_prev <= 1'b1;
         cas_prev <= 1'b1;
      end else begin
         ras_prev <= ras_n;
         cas_prev <= cas_n;
         if (ras_prev && !ras_n)
            ras_age <= 8'd1;
         else if (ras_age != 8'hFF)
            ras_age <= ras_age + 8'd1;
         if (cas_prev && !cas_n)
            cas_age <= 8'd1;
         else if (cas_age != 8'hFF)
            cas_age <= cas_age + 8'd1;
      end
   end

   p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   p_write_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !we_n) |-> dq_oe);

   p_rac_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (ras_age >= 8'(RAC_CYC)));

   p_cac_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (cas_age >= 8'(CAC_CYC)));

   p_row_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_age >= 8'(RC_CYC)));

   p_col_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (cas_age >= 8'(PC_CYC)));

   p_refresh_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_due |-> !req_ready);

   p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind dram_pm_ctrl dram_pm_ctrl_chk #(
   .RAC_CYC(RAC_CYC),
   .CAC_CYC(CAC_CYC),
   .RC_CYC (RC_CYC),
   .PC_CYC (PC_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_n    (dram_ras_n),
   .cas_n    (dram_cas_n),
   .we_n     (dram_we_n),
   .dq_oe    (dram_dq_oe),
   .rsp_valid(rsp_valid),
   .req_ready(req_ready),
   .ref_due  (ref_due)
);

// File: tb/dram_pm_ctrl_test.sv
module dram_pm_ctrl_test;
   localparam int CLK    = 10;
   localparam int RAC_C  = (60 + CLK - 1) / CLK;
   localparam int CAC_C  = (15 + CLK - 1) / CLK;
   localparam int RC_C   = (110 + CLK - 1) / CLK;
   localparam int PC_C   = (35 + CLK - 1) / CLK;
   localparam int REF_I  = 8000000 / (2048 * CLK);
   localparam int HIT_LAT  = 1 + CAC_C;
   localparam int OPEN_LAT = (RAC_C > 2 + CAC_C) ? RAC_C : 2 + CAC_C;

   // {write, row[10:0], col[10:0], data[15:0], kind[3:0]}  kind: 0 write, 1 hit, 2 open
   localparam logic [42:0] VEC [0:9] = '{
      {1'b1, 11'd5,    11'd3,    16'hA5A5, 4'd0},
      {1'b1, 11'd5,    11'd4,    16'h1234, 4'd0},
      {1'b0, 11'd5,    11'd3,    16'hA5A5, 4'd1},
      {1'b0, 11'd5,    11'd4,    16'h1234, 4'd1},
      {1'b1, 11'd9,    11'd3,    16'hBEEF, 4'd0},
      {1'b0, 11'd9,    11'd3,    16'hBEEF, 4'd1},
      {1'b0, 11'd5,    11'd3,    16'hA5A5, 4'd2},
      {1'b1, 11'd2047, 11'd2047, 16'hFFFF, 4'd0},
      {1'b0, 11'd2047, 11'd2047, 16'hFFFF, 4'd1},
      {1'b0, 11'd0,    11'd0,    16'h0000, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [21:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [10:0] dram_addr;
   logic [15:0] dram_dq_out;
   logic [15:0] dram_dq_in = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   dram_pm_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // DRAM model and timing monitor
   logic [15:0] mem [int];
   logic        prev_ras = 1'b1, prev_cas = 1'b1;
   int          last_ras_fall = -1000, last_cas_fall = -1000;
   int          ras_falls = 0, ref_count = 0, rsp_count = 0;
   int          last_ref_fall = -1;
   logic [10:0] lat_row = '0, lat_col = '0, exp_ref = '0;
   bit          saw_cas = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ras && !dram_ras_n) begin
            chk(cyc - last_ras_fall >= RC_C, "R5 row gap", cyc - last_ras_fall, RC_C);
            last_ras_fall = cyc;
            lat_row = dram_addr;
            saw_cas = 1'b0;
            ras_falls++;
         end
         if (!prev_ras && dram_ras_n && !saw_cas) begin
            chk(lat_row == exp_ref, "R9 refresh row", lat_row, exp_ref);
            if (ref_count > 0)
               chk(last_ras_fall - last_ref_fall <= REF_I + 40, "R9 R10 refresh gap",
                   last_ras_fall - last_ref_fall, REF_I);
            last_ref_fall = last_ras_fall;
            exp_ref = exp_ref + 11'd1;
            ref_count++;
         end
         if (prev_cas && !dram_cas_n) begin
            chk(cyc - last_cas_fall >= PC_C, "R6 column gap", cyc - last_cas_fall, PC_C);
            chk(!dram_ras_n, "R2 cas inside ras", dram_ras_n, 0);
            last_cas_fall = cyc;
            lat_col = dram_addr;
            saw_cas = 1'b1;
            if (!dram_we_n) begin
               chk(dram_dq_oe, "R3 data driven on write", dram_dq_oe, 1);
               mem[{lat_row, lat_col}] = dram_dq_out;
            end else begin
               dram_dq_in = mem.exists({lat_row, lat_col}) ? mem[{lat_row, lat_col}] : 16'h0000;
            end
         end
         if (rsp_valid) begin
            rsp_count++;
            chk(cyc - last_ras_fall >= RAC_C, "R4 ras to data", cyc - last_ras_fall, RAC_C);
            chk(cyc - last_cas_fall >= CAC_C, "R4 cas to data", cyc - last_cas_fall, CAC_C);
         end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
   end

   int reads_issued = 0;

   task automatic do_op(input logic wr, input logic [10:0] r, input logic [10:0] c,
                        input logic [15:0] d, input int kind, input logic [15:0] exp);
      int acc, rf0, n, lat;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = {r, c}; req_wdata = d;
      n = 0;
      #1;
      while (!req_ready && n < 300) begin
         @(negedge clk); #1; n++;
      end
      acc = cyc + 1;
      rf0 = ras_falls;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         reads_issued++;
         n = 0;
         while (!rsp_valid && n < 60) begin
            @(negedge clk); n++;
         end
         lat = cyc - acc;
         chk(rsp_valid && rsp_rdata == exp, "R3 R12 read data", rsp_rdata, exp);
         chk({lat_row, lat_col} == {r, c}, "R2 latched address", {lat_row, lat_col}, {r, c});
         if (kind == 1) begin
            chk(lat == HIT_LAT, "R7 R11 hit latency", lat, HIT_LAT);
            chk(ras_falls == rf0, "R7 no row strobe on hit", ras_falls - rf0, 0);
         end else if (kind == 2) begin
            chk(lat == OPEN_LAT, "R8 open latency", lat, OPEN_LAT);
            chk(last_ras_fall == acc, "R8 row opened at accept", last_ras_fall, acc);
         end else begin
            chk(lat == HIT_LAT || lat == OPEN_LAT, "R10 latency under refresh", lat, HIT_LAT);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
      chk(!dram_dq_oe && !rsp_valid, "R1 outputs quiet", {dram_dq_oe, rsp_valid}, 0);
      chk(req_ready, "R1 ready", req_ready, 1);

      for (int i = 0; i < 10; i++)
         do_op(VEC[i][42], VEC[i][41:31], VEC[i][30:20], VEC[i][19:4], int'(VEC[i][3:0]),
               VEC[i][19:4]);

      // continuous traffic across refresh deadlines
      begin
         int rc0;
         rc0 = ref_count;
         for (int k = 0; k < 220; k++)
            do_op(1'b0, 11'd9, 11'd3, 16'h0, 3, 16'hBEEF);
         chk(ref_count > rc0, "R10 refresh under traffic", ref_count - rc0, 1);
      end

      // write then read back after a row close, plus a write never answers
      do_op(1'b1, 11'd100, 11'd7, 16'h5A5A, 0, 16'h0);
      repeat (20) @(negedge clk);
      chk(rsp_count == reads_issued, "R12 no response on write", rsp_count, reads_issued);
      do_op(1'b0, 11'd100, 11'd7, 16'h0, 3, 16'h5A5A);

      repeat (1000) @(negedge clk);
      chk(ref_count >= 3, "R9 refresh count", ref_count, 3);
      chk(rsp_count == reads_issued, "R12 response count", rsp_count, reads_issued);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule